// File: doc/BRIEF.md
# Register Write-Protect Unlock Gate

This block holds one control register behind a write-protect flag. While the flag is set, writes to the control register are dropped and a sticky error bit is raised in a status register. The flag itself can be changed only after a fixed three-write key has been written across two unlock registers. This holds even when protection is already off. Completing the key opens the control register for exactly one write. That write may set or clear the flag together with all other control bits.

Software reaches the block through a plain single-cycle register port: an address, a write strobe, write data and read data. Reads are combinational from the current register state. A write takes effect at the clock edge that samples it. The control register value is also driven out on its own port for the logic it governs. Reset is asserted asynchronously and released through a two-stage synchroniser.

Top module: `wp_unlock_gate`

## Requirements
- R1: After reset, the control register reads 0x00000002 (protect flag, bit 1, set), the status register reads 0 and the key tracker is idle.
- R2: Offsets: control 0x00, first unlock register 0x18, second unlock register 0x1c, status 0x2c. The unlock registers and every other offset read as 0. Read data is combinational from the current address.
- R3: Writing 0x00007123 to offset 0x18, then 0x0000812a to offset 0x1c, then 0x0000bee1 to offset 0x18, as three consecutive writes, arms the gate. Cycles without a write between them do not disturb the sequence.
- R4: A write with a wrong value or to a wrong offset while the key is partly entered returns the tracker to idle. The key must then be entered again from its first write.
- R5: While armed, the next write to the control register stores all 32 bits, including bit 1. The gate is then disarmed.
- R6: A control write while not armed and with bit 1 of control set leaves the control register unchanged and sets status bit 1.
- R7: A control write while not armed and with bit 1 of control clear updates every control bit except bit 1, which keeps its value. It does not set status bit 1.
- R8: A status write with bit 1 of the data set clears status bit 1. With bit 1 of the data clear, it leaves status bit 1 unchanged. Status bits other than bit 1 read 0.
- R9: Writes to the unlock registers never set status bit 1, whatever their value.
- R10: While armed, any write other than to the control register disarms the gate without changing the control register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | ADDR_W (6) | Byte offset of the register accessed |
| reg_we | input | 1 | Write strobe, one write per cycle when high |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Combinational read data for reg_addr |
| ctrl_out | output | DATA_W (32) | Current control register value |

## Verification
Every register update lands at the clock edge that samples the write. A new value is therefore due one edge after the write is presented, on both ctrl_out and reg_rdata. Read data has no latency of its own: it follows reg_addr combinationally from the state at that moment. The bench drives inputs on the falling edge and advances its behavioural model right after the rising edge. It compares both outputs at the following falling edge, so every check samples half a cycle after the edge that is due to change them. After reset, the first sampled edge comes only after the two-stage release synchroniser, so the bench idles several cycles before its first comparison.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

  // register offsets (byte addresses)
  localparam int unsigned OFS_CTRL   = 32'h00;
  localparam int unsigned OFS_UNLK_A = 32'h18;
  localparam int unsigned OFS_UNLK_B = 32'h1c;
  localparam int unsigned OFS_STAT   = 32'h2c;

  // key words, in the order they must arrive
  localparam int unsigned KEY_FIRST  = 32'h7123;
  localparam int unsigned KEY_SECOND = 32'h812a;
  localparam int unsigned KEY_THIRD  = 32'hbee1;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_ONE   = 2'd1,
    KS_TWO   = 2'd2,
    KS_ARMED = 2'd3
  } key_st_e;

endpackage

// File: rtl/wpg_rst_sync.sv
module wpg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wpg_key_fsm.sv
module wpg_key_fsm
  import wpg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_any,
  input  logic              wr_unlk_a,
  input  logic              wr_unlk_b,
  input  logic [DATA_W-1:0] wdata,
  output logic              armed
);
  localparam logic [DATA_W-1:0] K1 = DATA_W'(KEY_FIRST);
  localparam logic [DATA_W-1:0] K2 = DATA_W'(KEY_SECOND);
  localparam logic [DATA_W-1:0] K3 = DATA_W'(KEY_THIRD);

  key_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (wr_any) begin
      st_d = KS_IDLE;
      unique case (st_q)
        KS_IDLE: if (wr_unlk_a && wdata == K1) st_d = KS_ONE;
        KS_ONE:  if (wr_unlk_b && wdata == K2) st_d = KS_TWO;
        KS_TWO:  if (wr_unlk_a && wdata == K3) st_d = KS_ARMED;
        default: st_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= KS_IDLE;
    else if (wr_any) st_q <= st_d;
  end

  assign armed = (st_q == KS_ARMED);
endmodule

// File: rtl/wpg_ctrl_reg.sv
module wpg_ctrl_reg #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PROT_BIT = 1,
  parameter int unsigned ERR_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_stat,
  input  logic              armed,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              err_q
);
  localparam logic [DATA_W-1:0] PROT_MASK = DATA_W'(1) << PROT_BIT;
  localparam logic [DATA_W-1:0] CTRL_RST  = PROT_MASK;

  logic              prot;
  logic              ctrl_en;
  logic [DATA_W-1:0] ctrl_d;
  logic              err_set, err_clr, err_en, err_d;

  assign prot = ctrl_q[PROT_BIT];

  always_comb begin
    ctrl_en = wr_ctrl && (armed || !prot);
    if (armed) ctrl_d = wdata;
    else       ctrl_d = (wdata & ~PROT_MASK) | (ctrl_q & PROT_MASK);
    err_set = wr_ctrl && !armed && prot;
    err_clr = wr_stat && wdata[ERR_BIT];
    err_en  = err_set || err_clr;
    err_d   = err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RST;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end
endmodule

// File: rtl/wp_unlock_gate.sv
module wp_unlock_gate
  import wpg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PROT_BIT = 1,
  parameter int unsigned ERR_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] ctrl_out
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_UNA  = ADDR_W'(OFS_UNLK_A);
  localparam logic [ADDR_W-1:0] A_UNB  = ADDR_W'(OFS_UNLK_B);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  logic              rst_sync_n;
  logic              wr_ctrl, wr_stat, wr_unlk_a, wr_unlk_b;
  logic              armed;
  logic              err_q;
  logic [DATA_W-1:0] ctrl_q;

  wpg_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    wr_ctrl   = reg_we && (reg_addr == A_CTRL);
    wr_stat   = reg_we && (reg_addr == A_STAT);
    wr_unlk_a = reg_we && (reg_addr == A_UNA);
    wr_unlk_b = reg_we && (reg_addr == A_UNB);
  end

  wpg_key_fsm #(.DATA_W(DATA_W)) i_key_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_any    (reg_we),
    .wr_unlk_a (wr_unlk_a),
    .wr_unlk_b (wr_unlk_b),
    .wdata     (reg_wdata),
    .armed     (armed)
  );

  wpg_ctrl_reg #(
    .DATA_W   (DATA_W),
    .PROT_BIT (PROT_BIT),
    .ERR_BIT  (ERR_BIT)
  ) i_ctrl_reg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_ctrl (wr_ctrl),
    .wr_stat (wr_stat),
    .armed   (armed),
    .wdata   (reg_wdata),
    .ctrl_q  (ctrl_q),
    .err_q   (err_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL)      reg_rdata = ctrl_q;
    else if (reg_addr == A_STAT) reg_rdata[ERR_BIT] = err_q;
  end

  assign ctrl_out = ctrl_q;
endmodule

// File: rtl/wp_unlock_gate_chk.sv
module wp_unlock_gate_chk
  import wpg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PROT_BIT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              err_q,
  input logic              armed
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_UNA  = ADDR_W'(OFS_UNLK_A);
  localparam logic [ADDR_W-1:0] A_UNB  = ADDR_W'(OFS_UNLK_B);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  assert_armed_by_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(reg_we) && $past(reg_addr) == A_UNA
                     && $past(reg_wdata) == DATA_W'(KEY_THIRD));

  assert_armed_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CTRL && armed) |=> (!armed && ctrl_q == $past(reg_wdata)));

  assert_blocked_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CTRL && !armed && ctrl_q[PROT_BIT]) |=> ($stable(ctrl_q) && err_q));

  assert_prot_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CTRL && !armed) |=> $stable(ctrl_q[PROT_BIT]));

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_STAT && reg_wdata[1]) |=> !err_q);

  assert_unlock_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == A_UNA || reg_addr == A_UNB) && !err_q) |=> !err_q);

  assert_disarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr != A_CTRL && armed) |=> (!armed && $stable(ctrl_q)));
endmodule

bind wp_unlock_gate wp_unlock_gate_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .PROT_BIT (PROT_BIT)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_addr  (reg_addr),
  .reg_we    (reg_we),
  .reg_wdata (reg_wdata),
  .ctrl_q    (ctrl_q),
  .err_q     (err_q),
  .armed     (armed)
);

// File: tb/test_wp_unlock_gate.sv
`timescale 1ns/1ps
module test_wp_unlock_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] ctrl_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string req = "R1";

  // behavioural reference state
  int unsigned m_ctrl = 32'h2;
  bit          m_err = 1'b0;
  int          m_key = 0;   // number of key words accepted, 3 = open

  always #10 clk = ~clk;

  wp_unlock_gate i_wp_unlock_gate (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl_out(ctrl_out)
  );

  function automatic int unsigned m_read(input int unsigned a);
    if (a == 32'h00) return m_ctrl;
    if (a == 32'h2c) return m_err ? 32'h2 : 32'h0;
    return 0;
  endfunction

  task automatic m_step(input bit we, input int unsigned a, input int unsigned d);
    if (!we) return;
    if (a == 32'h00) begin
      if (m_key == 3)          m_ctrl = d;
      else if (m_ctrl[1])      m_err = 1'b1;
      else                     m_ctrl = (d & ~32'h2) | (m_ctrl & 32'h2);
      m_key = 0;
    end else if (a == 32'h18) begin
      if (m_key == 0 && d == 32'h7123)      m_key = 1;
      else if (m_key == 2 && d == 32'hbee1) m_key = 3;
      else                                  m_key = 0;
    end else if (a == 32'h1c) begin
      m_key = (m_key == 1 && d == 32'h812a) ? 2 : 0;
    end else begin
      if (a == 32'h2c && d[1]) m_err = 1'b0;
      m_key = 0;
    end
  endtask

  task automatic compare();
    checks++;
    if (ctrl_out !== m_ctrl) begin
      fails++;
      $display("FAIL %s ctrl_out actual %h expected %h", req, ctrl_out, m_ctrl);
    end
    checks++;
    if (reg_rdata !== m_read(32'(reg_addr))) begin
      fails++;
      $display("FAIL %s rdata@%h actual %h expected %h", req, reg_addr, reg_rdata,
               m_read(32'(reg_addr)));
    end
  endtask

  // called on a falling edge; returns on the next falling edge after comparing
  task automatic step(input bit we, input int unsigned a, input int unsigned d);
    reg_we = we; reg_addr = a[5:0]; reg_wdata = d;
    @(posedge clk);
    m_step(we, a, d);
    @(negedge clk);
    reg_we = 1'b0;
    compare();
  endtask

  task automatic wr(input int unsigned a, input int unsigned d);
    step(1'b1, a, d);
  endtask

  task automatic rd(input int unsigned a);
    step(1'b0, a, 0);
  endtask

  task automatic key();
    wr(32'h18, 32'h7123); wr(32'h1c, 32'h812a); wr(32'h18, 32'hbee1);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog expired during %s", req);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    req = "R1"; rd(32'h00); rd(32'h2c);
    // R2: unlock registers and unmapped offsets read as zero
    req = "R2"; rd(32'h18); rd(32'h1c); rd(32'h04); rd(32'h3c);
    // R6: protected, not armed -> dropped, error set
    req = "R6"; wr(32'h00, 32'h55); rd(32'h2c); rd(32'h00);
    // R8: W1C behaviour
    req = "R8"; wr(32'h2c, 32'hfffd); rd(32'h2c); wr(32'h2c, 32'h2); rd(32'h2c);
    // R9: unlock writes with junk never raise the error
    req = "R9"; wr(32'h18, 32'hdead); wr(32'h1c, 32'h0); rd(32'h2c);
    // R3 + R5: key then clear protect in one write
    req = "R3"; wr(32'h18, 32'h7123); rd(32'h00); wr(32'h1c, 32'h812a); rd(32'h2c);
    wr(32'h18, 32'hbee1);
    req = "R5"; wr(32'h00, 32'h1234); rd(32'h00); rd(32'h2c);
    // R7: unprotected, not armed: bit 1 holds
    req = "R7"; wr(32'h00, 32'hffff_ffff); rd(32'h00); wr(32'h00, 32'h0);
    wr(32'h00, 32'h2); rd(32'h00); rd(32'h2c);
    // R5: re-protect through key, then unlock consumed
    req = "R5"; key(); wr(32'h00, 32'h6); rd(32'h00);
    wr(32'h00, 32'h0); rd(32'h00); rd(32'h2c); wr(32'h2c, 32'h2);
    // R4: broken sequences
    req = "R4";
    wr(32'h18, 32'h7123); wr(32'h1c, 32'h812b); wr(32'h18, 32'hbee1);
    wr(32'h00, 32'h0); rd(32'h00); wr(32'h2c, 32'h2);
    wr(32'h18, 32'h7123); wr(32'h18, 32'h812a); wr(32'h18, 32'hbee1);
    wr(32'h00, 32'h0); rd(32'h00); wr(32'h2c, 32'h2);
    wr(32'h18, 32'h7123); wr(32'h1c, 32'h812a); wr(32'h04, 32'h1);
    wr(32'h18, 32'hbee1); wr(32'h00, 32'h0); rd(32'h00); wr(32'h2c, 32'h2);
    // R3: idle cycles inside the key are harmless
    req = "R3"; wr(32'h18, 32'h7123); rd(32'h00); rd(32'h00);
    wr(32'h1c, 32'h812a); rd(32'h2c); wr(32'h18, 32'hbee1); rd(32'h00);
    wr(32'h00, 32'h8); rd(32'h00);
    // R10: armed then a non-control write disarms
    req = "R10"; key(); wr(32'h00, 32'ha); key(); wr(32'h2c, 32'h0);
    wr(32'h00, 32'h0); rd(32'h00); rd(32'h2c);
    key(); wr(32'h1c, 32'h812a); wr(32'h00, 32'h0); rd(32'h00);
    finish_run();
  end
endmodule